// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block brings a low-power single-data-rate SDRAM from reset to a usable state. From reset it holds the clock-enable pin high and puts only no-operation commands on the bus until the power-stabilisation wait has run out. It then issues one precharge of all banks. Next comes a configurable number of auto-refresh commands, never fewer than two. After that it writes the normal mode register and then the extended (low-power) mode register, and finally raises `done`. Every wait is a parameter in nanoseconds or microseconds. Each wait becomes a clock count, rounded up, from the clock frequency parameter.

Once `done` is high, the memory controller may ask for a new extended-mode write. It does this to change the self-refresh array size or the output drive strength without running the whole start-up again. The request is taken only while the controller reports every bank idle. The sequencer keeps a two-clock gap after each mode write before it takes another command.

The command bus is one 4-bit field `cmd_n = {cs_n, ras_n, cas_n, we_n}`, with a bank-select pair and a 13-bit address. All command outputs are registered.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is held and afterwards, `cke` is 1. From reset the bus carries NOP (`cmd_n`=0111, `ba`=00, `addr`=0). The first non-NOP command appears on the output after clock edge STABLE_CYC = CLK_MHZ*STABLE_US, where clock edge 1 is the first rising edge after reset is released.
- R2: The first command is precharge-all: `cmd_n`=0010, `addr`=13'h0400 (only A10 set) and `ba`=00.
- R3: After the precharge come max(2, `cfg_ref_cnt`) auto-refresh commands (`cmd_n`=0001, `addr`=0, `ba`=00). The first follows the precharge by TRP_CYC clocks and each later one follows the previous refresh by TRC_CYC clocks.
- R4: TRC_CYC clocks after the last refresh, the normal mode write appears: `cmd_n`=0000, `ba`=00. Its `addr` holds burst length in [2:0], burst type in [3], CAS latency code in [6:4], write-single bit in [9], and zeros in [12:10] and [8:7].
- R5: Exactly 2 clocks after the normal mode write, the extended mode write appears: `cmd_n`=0000, `ba`=10. Its `addr` holds the self-refresh array code in [2:0] and the drive-strength code in [6:5], with all other bits 0.
- R6: Every output cycle that is not one of the commands above carries NOP with `addr`=0 and `ba`=00. In particular, the cycle right after any mode write is always NOP.
- R7: `done` rises 2 clocks after the boot-time extended mode write and stays high until the next reset.
- R8: With `done` high, if `upd_req` and `banks_idle` are both 1 at a rising edge and the previous mode write is at least 2 clocks old, an extended mode write built from the current `cfg_pasr` and `cfg_drive` appears after that edge. A request held high gives one write every second clock.
- R9: `upd_req` has no effect before `done` rises or while `banks_idle` is 0: the bus shows the boot sequence, or NOP once booted.
- R10: The clock counts come from the nanosecond parameters by rounding ns*CLK_MHZ/1000 up, with a minimum of 1. TRP_CYC comes from TRP_NS and TRC_CYC from TRC_NS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for normal mode word |
| cfg_burst_ilv | input | 1 | Burst type bit (1 = interleaved) |
| cfg_cas | input | 3 | CAS latency code (001=1, 010=2, 011=3) |
| cfg_wr_single | input | 1 | Single-beat write bit |
| cfg_ref_cnt | input | REFW | Requested refresh count (at least 2 are issued) |
| cfg_pasr | input | 3 | Self-refresh array code (000 full, 001 half, 010 quarter) |
| cfg_drive | input | 2 | Drive strength code (00 full, 01 half) |
| upd_req | input | 1 | Request an extended mode rewrite after boot |
| banks_idle | input | 1 | All banks are idle, from the controller |
| cke | output | 1 | Clock enable to the memory |
| cmd_n | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| ba | output | 2 | Bank-select / mode-register key |
| addr | output | 13 | Address / mode word |
| done | output | 1 | Start-up finished |

## Verification
Boots are run with requested refresh counts of 0, 1, 2 and larger values. These show whether the minimum of two refreshes is enforced and whether the refresh spacing and the mode-write time shift correctly with the count. The mode-word fields take random values in every boot, so a field placed on the wrong bit shows up as a wrong address. During boot, `upd_req` and `banks_idle` toggle randomly to prove they are ignored. After boot, directed cases (request while banks are busy, a single request, a request held high) and a long random stretch are compared with a bench model of the two-clock gap. This separates a missing gap, a missing bank-idle check and a stale field.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_STABLE,
    ST_PRE_WAIT,
    ST_REF_WAIT,
    ST_MRS_WAIT,
    ST_EXT_WAIT,
    ST_READY
  } state_e;

  typedef enum logic [2:0] {
    ISS_NONE,
    ISS_PRE,
    ISS_REF,
    ISS_NMODE,
    ISS_XMODE
  } issue_e;

  localparam logic [1:0] BA_NORMAL = 2'b00;
  localparam logic [1:0] BA_EXT    = 2'b10;
  localparam int         ADDR_W    = 13;

  // Round a time in ns up to whole clocks, never below one clock.
  function automatic int ns_to_cycles(int ns, int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  // The memory needs at least two refreshes during start-up.
  function automatic int eff_refs(int req);
    return (req < 2) ? 2 : req;
  endfunction

  function automatic logic [ADDR_W-1:0] normal_word(logic [2:0] bl, logic bt,
                                                     logic [2:0] cas, logic wsb);
    return {3'b000, wsb, 2'b00, cas, bt, bl};
  endfunction

  function automatic logic [ADDR_W-1:0] ext_word(logic [2:0] pasr, logic [1:0] ds);
    return {6'b000000, ds, 2'b00, pasr};
  endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int W    = 16,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= W'(INIT);
    else if (load)     cnt <= load_val;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import sdram_boot_pkg::*;
#(
  parameter int TW       = 16,
  parameter int RW       = 4,
  parameter int TRP_CYC  = 2,
  parameter int TRC_CYC  = 7,
  parameter int TMRD_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_zero,
  input  logic [RW-1:0] cfg_ref_cnt,
  input  logic          upd_req,
  input  logic          banks_idle,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output issue_e        issue,
  output logic          ready
);
  localparam logic [TW-1:0] TRP_V = TW'(TRP_CYC - 1);
  localparam logic [TW-1:0] TRC_V = TW'(TRC_CYC - 1);
  localparam logic [TW-1:0] MRD_V = TW'(TMRD_CYC - 1);

  state_e        st, st_nx;
  logic [RW-1:0] refs_left, refs_nx;

  always_comb begin
    st_nx    = st;
    refs_nx  = refs_left;
    issue    = ISS_NONE;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      ST_STABLE: if (tmr_zero) begin
        issue = ISS_PRE; tmr_load = 1'b1; tmr_val = TRP_V; st_nx = ST_PRE_WAIT;
      end
      ST_PRE_WAIT: if (tmr_zero) begin
        issue = ISS_REF; tmr_load = 1'b1; tmr_val = TRC_V;
        refs_nx = RW'(eff_refs(int'(cfg_ref_cnt)) - 1);
        st_nx = ST_REF_WAIT;
      end
      ST_REF_WAIT: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (refs_left != '0) begin
          issue = ISS_REF; tmr_val = TRC_V; refs_nx = refs_left - 1'b1;
        end else begin
          issue = ISS_NMODE; tmr_val = MRD_V; st_nx = ST_MRS_WAIT;
        end
      end
      ST_MRS_WAIT: if (tmr_zero) begin
        issue = ISS_XMODE; tmr_load = 1'b1; tmr_val = MRD_V; st_nx = ST_EXT_WAIT;
      end
      ST_EXT_WAIT: if (tmr_zero) st_nx = ST_READY;
      ST_READY: if (tmr_zero && upd_req && banks_idle) begin
        issue = ISS_XMODE; tmr_load = 1'b1; tmr_val = MRD_V;
      end
      default: st_nx = ST_STABLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_STABLE;
      refs_left <= '0;
    end else begin
      st        <= st_nx;
      refs_left <= refs_nx;
    end
  end

  assign ready = (st == ST_READY);
endmodule

// File: rtl/boot_cmd_drv.sv
module boot_cmd_drv
  import sdram_boot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  issue_e            issue,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_ilv,
  input  logic [2:0]        cfg_cas,
  input  logic              cfg_wr_single,
  input  logic [2:0]        cfg_pasr,
  input  logic [1:0]        cfg_drive,
  output logic              cke,
  output cmd_e              cmd_q,
  output logic [1:0]        ba_q,
  output logic [ADDR_W-1:0] addr_q
);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke    <= 1'b1;
      cmd_q  <= CMD_NOP;
      ba_q   <= 2'b00;
      addr_q <= '0;
    end else begin
      cke <= 1'b1;
      case (issue)
        ISS_PRE: begin
          cmd_q <= CMD_PRE; ba_q <= 2'b00; addr_q <= ALL_BANKS;
        end
        ISS_REF: begin
          cmd_q <= CMD_REF; ba_q <= 2'b00; addr_q <= '0;
        end
        ISS_NMODE: begin
          cmd_q  <= CMD_MRS; ba_q <= BA_NORMAL;
          addr_q <= normal_word(cfg_burst_len, cfg_burst_ilv, cfg_cas, cfg_wr_single);
        end
        ISS_XMODE: begin
          cmd_q  <= CMD_MRS; ba_q <= BA_EXT;
          addr_q <= ext_word(cfg_pasr, cfg_drive);
        end
        default: begin
          cmd_q <= CMD_NOP; ba_q <= 2'b00; addr_q <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int STABLE_US = 200,
  parameter int TRP_NS    = 18,
  parameter int TRC_NS    = 63,
  parameter int TMRD_CYC  = 2,
  parameter int REFW      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      cfg_burst_len,
  input  logic            cfg_burst_ilv,
  input  logic [2:0]      cfg_cas,
  input  logic            cfg_wr_single,
  input  logic [REFW-1:0] cfg_ref_cnt,
  input  logic [2:0]      cfg_pasr,
  input  logic [1:0]      cfg_drive,
  input  logic            upd_req,
  input  logic            banks_idle,
  output logic            cke,
  output logic [3:0]      cmd_n,
  output logic [1:0]      ba,
  output logic [12:0]     addr,
  output logic            done
);
  localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int TRP_CYC    = ns_to_cycles(TRP_NS, CLK_MHZ);
  localparam int TRC_CYC    = ns_to_cycles(TRC_NS, CLK_MHZ);
  localparam int TW         = $clog2(STABLE_CYC + TRC_CYC + TRP_CYC + TMRD_CYC + 1);

  // Named internal events, brought out for the checker.
  logic          tmr_zero;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  issue_e        issue;
  cmd_e          cmd_q;

  boot_timer #(.W(TW), .INIT(STABLE_CYC - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  boot_ctrl #(
    .TW(TW), .RW(REFW), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC), .TMRD_CYC(TMRD_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_zero    (tmr_zero),
    .cfg_ref_cnt (cfg_ref_cnt),
    .upd_req     (upd_req),
    .banks_idle  (banks_idle),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .issue       (issue),
    .ready       (done)
  );

  boot_cmd_drv u_drv (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue         (issue),
    .cfg_burst_len (cfg_burst_len),
    .cfg_burst_ilv (cfg_burst_ilv),
    .cfg_cas       (cfg_cas),
    .cfg_wr_single (cfg_wr_single),
    .cfg_pasr      (cfg_pasr),
    .cfg_drive     (cfg_drive),
    .cke           (cke),
    .cmd_q         (cmd_q),
    .ba_q          (ba),
    .addr_q        (addr)
  );

  assign cmd_n = cmd_q;
endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk
  import sdram_boot_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cke,
  input logic [3:0]  cmd_n,
  input logic [1:0]  ba,
  input logic [12:0] addr,
  input logic        done,
  input logic        upd_req,
  input logic        banks_idle,
  input logic        tmr_zero,
  input issue_e      issue
);
  a_r1_cke_high: assert property (@(posedge clk) disable iff (!rst_n) cke);

  a_r2_precharge_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == CMD_PRE) |-> (addr == 13'h0400 && ba == 2'b00));

  a_r4_normal_word_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == CMD_MRS && ba == BA_NORMAL) |-> (addr[12:10] == 3'b000 && addr[8:7] == 2'b00 && !done));

  a_r5_ext_word_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == CMD_MRS) |-> ((ba == BA_NORMAL) ||
                            (ba == BA_EXT && addr[12:7] == 6'd0 && addr[4:3] == 2'b00)));

  a_r6_nop_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_n == CMD_MRS) |=> (cmd_n == CMD_NOP));

  a_r6_issue_reaches_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (issue != ISS_NONE) |=> (cmd_n != CMD_NOP));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r7_done_after_ext: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(cmd_n, 2) == CMD_MRS && $past(ba, 2) == BA_EXT));

  a_r8_gap_running: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd_n == CMD_MRS) |-> !tmr_zero);

  a_r9_update_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cmd_n == CMD_MRS) |-> ($past(upd_req) && $past(banks_idle)));
endmodule

bind sdram_boot_seq sdram_boot_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke        (cke),
  .cmd_n      (cmd_n),
  .ba         (ba),
  .addr       (addr),
  .done       (done),
  .upd_req    (upd_req),
  .banks_idle (banks_idle),
  .tmr_zero   (tmr_zero),
  .issue      (issue)
);

// File: tb/sdram_boot_seq_test.sv
module sdram_boot_seq_test;
  localparam int MHZ   = 100;
  localparam int SUS   = 20;
  localparam int TRPNS = 18;
  localparam int TRCNS = 63;

  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MODE = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bl = '0, cas = '0, pasr = '0;
  logic bt = 1'b0, ws = 1'b0, req = 1'b0, idle = 1'b0;
  logic [3:0] refc = '0;
  logic [1:0] ds = '0;
  logic cke, done;
  logic [3:0] cmd_n;
  logic [1:0] ba;
  logic [12:0] addr;

  int checks = 0, fails = 0, since = 2;

  always #5 clk = ~clk;

  sdram_boot_seq #(.CLK_MHZ(MHZ), .STABLE_US(SUS), .TRP_NS(TRPNS), .TRC_NS(TRCNS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_len(bl), .cfg_burst_ilv(bt), .cfg_cas(cas),
    .cfg_wr_single(ws), .cfg_ref_cnt(refc), .cfg_pasr(pasr), .cfg_drive(ds),
    .upd_req(req), .banks_idle(idle), .cke(cke), .cmd_n(cmd_n), .ba(ba), .addr(addr), .done(done));

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // R10: smallest whole clock count covering the time.
  function automatic int to_cyc(int ns);
    int c = 0;
    while (c * 1000 < ns * MHZ) c++;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic logic [12:0] nword(logic [2:0] l, logic t, logic [2:0] c, logic w);
    logic [12:0] x = '0;
    x[2:0] = l; x[3] = t; x[6:4] = c; x[9] = w;
    return x;
  endfunction

  function automatic logic [12:0] xword(logic [2:0] p, logic [1:0] d);
    logic [12:0] x = '0;
    x[2:0] = p; x[6:5] = d;
    return x;
  endfunction

  task automatic boot(input logic [3:0] rc, input bit noisy);
    int trp, trc, t_pre, nref, t_mrs, t_x, t_done, seen_ref, bad_nop, bad_done;
    logic [3:0] ec;
    logic [12:0] ea;
    logic [1:0] eb;
    trp = to_cyc(TRPNS); trc = to_cyc(TRCNS);
    bl = 3'($urandom); bt = 1'($urandom); cas = 3'($urandom); ws = 1'($urandom);
    pasr = 3'($urandom); ds = 2'($urandom); refc = rc; req = 1'b0; idle = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(cke == 1'b1 && cmd_n == C_NOP && addr == 0 && ba == 0 && done == 1'b0,
          "R1", "reset state", {cke, done, cmd_n}, {1'b1, 1'b0, C_NOP});
    rst_n = 1'b1;
    t_pre = SUS * MHZ;
    nref = (rc < 2) ? 2 : int'(rc);
    t_mrs = t_pre + trp + nref * trc;
    t_x = t_mrs + 2;
    t_done = t_x + 2;
    seen_ref = 0; bad_nop = 0; bad_done = 0;
    for (int k = 1; k <= t_done + 3; k++) begin
      if (noisy && k <= t_done) begin
        req = 1'($urandom); idle = 1'($urandom);
      end else begin
        req = 1'b0; idle = 1'b0;
      end
      @(negedge clk);
      ec = C_NOP; ea = '0; eb = 2'b00;
      if (k == t_pre) begin ec = C_PRE; ea = 13'h0400; end
      else if (k >= t_pre + trp && k < t_mrs && (k - t_pre - trp) % trc == 0) ec = C_REF;
      else if (k == t_mrs) begin ec = C_MODE; ea = nword(bl, bt, cas, ws); end
      else if (k == t_x) begin ec = C_MODE; eb = 2'b10; ea = xword(pasr, ds); end
      if (ec == C_PRE)
        check(cmd_n == ec && addr == ea && ba == eb, "R2", "precharge-all", {cmd_n, ba, addr}, {ec, eb, ea});
      else if (ec == C_REF) begin
        check(cmd_n == ec && addr == 0 && ba == 0, "R3", "refresh slot", {cmd_n, ba, addr}, {ec, eb, ea});
        if (cmd_n == C_REF) seen_ref++;
      end else if (ec == C_MODE && eb == 2'b00)
        check(cmd_n == ec && addr == ea && ba == eb, "R4", "normal mode word", {cmd_n, ba, addr}, {ec, eb, ea});
      else if (ec == C_MODE)
        check(cmd_n == ec && addr == ea && ba == eb, "R5", "extended mode word", {cmd_n, ba, addr}, {ec, eb, ea});
      else if (!(cmd_n == C_NOP && addr == 0 && ba == 0)) begin
        bad_nop++;
        if (bad_nop == 1)
          check(1'b0, (k < t_pre) ? "R1" : (noisy ? "R9" : "R6"), "unexpected command", {cmd_n, ba, addr}, {C_NOP, 15'd0});
      end
      if (done != (k >= t_done)) bad_done++;
      if (cke != 1'b1) bad_done++;
    end
    check(bad_nop == 0, noisy ? "R9" : "R6", "NOP cycles clean", bad_nop, 0);
    check(seen_ref == nref, "R3", "refresh count", seen_ref, nref);
    check(bad_done == 0, "R7", "done timing and cke", bad_done, 0);
    since = 2;
  endtask

  // One post-boot cycle against the gap model (R8, R9).
  task automatic step(input logic r, input logic i, input string rq);
    bit acc;
    logic [12:0] ea;
    req = r; idle = i; pasr = 3'($urandom); ds = 2'($urandom);
    ea = xword(pasr, ds);
    acc = r && i && (since >= 2);
    @(negedge clk);
    if (acc)
      check(cmd_n == C_MODE && ba == 2'b10 && addr == ea && done, rq, "update write", {cmd_n, ba, addr}, {C_MODE, 2'b10, ea});
    else
      check(cmd_n == C_NOP && addr == 0 && done, rq, "no update", {cmd_n, ba, addr}, {C_NOP, 15'd0});
    since = acc ? 1 : since + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    check(to_cyc(TRPNS) == 2 && to_cyc(TRCNS) == 7, "R10", "rounded clock counts",
          to_cyc(TRPNS) * 16 + to_cyc(TRCNS), 39);
    boot(4'd0, 1'b0);   // clamp to two refreshes (R3)
    repeat (3) step(1'b1, 1'b0, "R9");          // banks busy
    step(1'b1, 1'b1, "R8");
    step(1'b0, 1'b1, "R8");
    repeat (5) step(1'b1, 1'b1, "R8");          // held request: every second clock
    boot(4'd1, 1'b1);   // clamp, noisy requests during boot (R9)
    for (int n = 0; n < 150; n++) step(1'($urandom), 1'($urandom), "R8");
    boot(4'd2, 1'b1);
    boot(4'd9, 1'b0);
    for (int n = 0; n < 100; n++) step(1'($urandom), 1'($urandom), "R8");
    summary();
    $finish;
  end
endmodule